// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Front End

This block is a single-port synchronous memory with a registered command stage, a one-cycle read pipeline and a deferred write buffer. On every rising clock edge it samples the address, the active-low select, the active-low write enable, four active-low byte enables and an active-low output enable. A read returns its word from an output register one edge later. A write takes its data one edge after its address. That data then waits in a buffer and reaches the array only when the next write's data arrives.

Because buffered data is not yet in the array, a read whose address equals the buffered address is served from the buffer. This is decided byte by byte: each buffered byte has a valid bit taken from its byte enable, and bytes that were not written come from the array. A sleep input freezes the block: commands and write data are ignored, the output flag drops, and the array and buffer keep their contents. The data bus is split into an input port and an output port. An output-enable flag stands in for the high-impedance state. The array is a small behavioural register file.

Top module: `lw_sram_ctrl`

## Requirements
- R1: After reset, `rdata_en` is 0, `rdata` is all zeros, the array is cleared, and the write buffer holds no valid byte.
- R2: A read sampled at clock edge n (sel_n=0, we_n=1, sleep=0) shows its word on `rdata` after edge n+1. `rdata_en` is 1 then only if oe_n was 0 at edge n.
- R3: For a write sampled at edge n (sel_n=0, we_n=0), the data is taken from `wdata` at edge n+1, whatever the control inputs are at that edge.
- R4: A buffered write enters the array at the edge that captures the data of the next write, and only its valid bytes are written. Until then, reads of other addresses and later reads see the array.
- R5: A read of the buffered address takes each byte from the buffer when that byte is valid, and from the array otherwise.
- R6: Byte k occupies `wdata`/`rdata` bits [9k+8:9k]. be_n bit k low writes byte k. A write with be_n=4'b1111 writes no byte, but it still commits the older buffer entry.
- R7: Consecutive reads of the same address with no write between them leave `rdata` unchanged.
- R8: With sel_n=1 at edge n, the cycle does nothing. `rdata_en` is 0 after edge n+1, and `rdata` keeps its value.
- R9: With oe_n=1 sampled alongside a read, `rdata_en` is 0 after the following edge. The read word is still loaded into `rdata`.
- R10: While sleep=1, commands and write data are ignored, array and buffer contents are kept, and `rdata_en` is 0 after every edge at which sleep was 1.
- R11: In back-to-back writes, the older entry is committed at the same edge at which the newer data is captured. The bypass comparison always uses the newest buffered address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request; freezes the block while high |
| sel_n | input | 1 | Active-low cycle select |
| we_n | input | 1 | Active-low write enable (high = read) |
| be_n | input | 4 | Active-low byte write enables, bit k for byte k |
| addr | input | 4 | Word address |
| wdata | input | 36 | Write data, taken one edge after the write command |
| oe_n | input | 1 | Active-low output enable, sampled with the command |
| rdata | output | 36 | Registered read data |
| rdata_en | output | 1 | High when the output bus would be driven, low for high-impedance |

## Verification
The embedded properties check every cycle that sleep, deselect and a high output enable each force the output flag low at the right edge. They also check that repeated same-address reads hold `rdata` steady, that the write buffer changes only on a data capture, and that array commits happen only at write-data edges. Which bytes come from the buffer and which from the array, the correct late-commit ordering across interleaved writes, the effect of an all-bytes-disabled write, and keeping memory contents across sleep can only be shown by the bench's scenarios, which compare read words against hand-computed values.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_cmd_reg.sv
module lw_cmd_reg
  import lw_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          sel_n,
  input  logic          we_n,
  input  logic [NB-1:0] be_n,
  input  logic [AW-1:0] addr,
  input  logic          oe_n,
  output lw_op_e        op_q,
  output logic [AW-1:0] addr_q,
  output logic [NB-1:0] ben_q,
  output logic          oe_q
);
  // command stage: everything except write data is registered here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      addr_q <= '0;
      ben_q  <= '0;
      oe_q   <= 1'b0;
    end else if (sleep || sel_n) begin
      op_q <= OP_NOP;
      oe_q <= 1'b0;
    end else begin
      op_q   <= we_n ? OP_READ : OP_WRITE;
      addr_q <= addr;
      ben_q  <= ~be_n;
      oe_q   <= ~oe_n;
    end
  end
endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] addr_q,
  input  logic [NB-1:0] ben_q,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data,
  output logic [NB-1:0] buf_vld,
  output logic [NB-1:0] commit_be
);
  // the older entry drains into the array as the newer one lands (R4, R11)
  assign commit_be = capture ? buf_vld : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr <= '0;
      buf_data <= '0;
      buf_vld  <= '0;
    end else if (capture) begin
      buf_addr <= addr_q;
      buf_data <= wdata;
      buf_vld  <= ben_q;
    end
  end

  assert_buf_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(buf_addr) && $stable(buf_vld) && $stable(buf_data)));
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] wr_be,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) lane[i] <= '0;
      end else if (wr_be[b]) begin
        lane[waddr] <= wdata[b*BW +: BW];
      end
    end

    assign rdata[b*BW +: BW] = lane[raddr];
  end
endmodule

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             sel_n,
  input  logic             we_n,
  input  logic [NB-1:0]    be_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  input  logic             oe_n,
  output logic [NB*BW-1:0] rdata,
  output logic             rdata_en
);
  localparam int DW = NB * BW;

  lw_op_e        op_q;
  logic [AW-1:0] addr_q;
  logic [NB-1:0] ben_q;
  logic          oe_q;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic [NB-1:0] buf_vld;
  logic [NB-1:0] commit_be;
  logic [DW-1:0] arr_rd;
  logic [DW-1:0] merged;
  logic          capture;
  logic          rd_fire;

  assign capture = (op_q == OP_WRITE) && !sleep;
  assign rd_fire = (op_q == OP_READ) && !sleep;

  lw_cmd_reg #(.AW(AW), .NB(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .we_n(we_n),
    .be_n(be_n), .addr(addr), .oe_n(oe_n),
    .op_q(op_q), .addr_q(addr_q), .ben_q(ben_q), .oe_q(oe_q)
  );

  lw_write_buffer #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .capture(capture), .addr_q(addr_q),
    .ben_q(ben_q), .wdata(wdata),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_vld(buf_vld),
    .commit_be(commit_be)
  );

  lw_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_be(commit_be), .waddr(buf_addr),
    .wdata(buf_data), .raddr(addr_q), .rdata(arr_rd)
  );

  // per-byte bypass from the pending write (R5)
  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*BW +: BW] = (buf_vld[b] && (buf_addr == addr_q))
                                ? buf_data[b*BW +: BW] : arr_rd[b*BW +: BW];
  end

  // output register: data loads only on reads, so repeats stay glitch-free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_en <= 1'b0;
    end else begin
      rdata_en <= rd_fire && oe_q;
      if (rd_fire) rdata <= merged;
    end
  end

  assert_sleep_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdata_en);

  assert_desel_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> ##2 !rdata_en);

  assert_oe_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> ##2 !rdata_en);

  assert_repeat_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && $past(rd_fire) && (addr_q == $past(addr_q))) |=> $stable(rdata));

  assert_commit_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit_be) |-> (op_q == OP_WRITE));
endmodule

// File: tb/lw_sram_ctrl_tb.sv
`timescale 1ns/1ps
module lw_sram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        sel_n = 1'b1;
  logic        we_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [3:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic [35:0] rdata;
  logic        rdata_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lw_sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .we_n(we_n),
    .be_n(be_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  localparam logic [35:0] Z0 = 36'd0;
  localparam logic [35:0] D1 = {9'h111, 9'h122, 9'h133, 9'h144};
  localparam logic [35:0] D2 = {9'h1F0, 9'h1E1, 9'h1D2, 9'h0C3};
  localparam logic [35:0] D3 = {9'h0A5, 9'h15A, 9'h0F0, 9'h10F};
  localparam logic [35:0] D4 = {9'h1AB, 9'h0CD, 9'h1EF, 9'h012};
  localparam logic [35:0] D5 = {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF};
  localparam logic [35:0] D6 = {9'h055, 9'h0AA, 9'h155, 9'h1AA};
  localparam logic [35:0] D7 = {9'h001, 9'h002, 9'h003, 9'h004};
  localparam logic [35:0] M1 = {9'h111, 9'h122, 9'h133, 9'h0C3};
  localparam logic [35:0] M2 = {9'h1AB, 9'h000, 9'h1EF, 9'h000};

  typedef struct packed {
    logic        sel_n;
    logic        we_n;
    logic [3:0]  be_n;
    logic [3:0]  addr;
    logic [35:0] wd;
    logic        oe_n;
    logic [3:0]  req;
    logic        en_x;
    logic [35:0] dat_x;
  } row_t;

  // each row: inputs before an edge, expected outputs after it
  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    '{1'b0, 1'b0, 4'b0000, 4'd1, Z0, 1'b0, 4'd2,  1'b0, Z0}, // write a1 (R2 idle out)
    '{1'b1, 1'b1, 4'b1111, 4'd0, D1, 1'b0, 4'd3,  1'b0, Z0}, // R3 data follows address
    '{1'b0, 1'b1, 4'b1111, 4'd1, Z0, 1'b0, 4'd8,  1'b0, Z0}, // read a1
    '{1'b0, 1'b1, 4'b1111, 4'd2, Z0, 1'b0, 4'd5,  1'b1, D1}, // R5 full bypass
    '{1'b0, 1'b0, 4'b1110, 4'd1, Z0, 1'b0, 4'd2,  1'b1, Z0}, // R2 array word a2
    '{1'b0, 1'b1, 4'b1111, 4'd1, D2, 1'b0, 4'd4,  1'b0, Z0}, // R4 D1 committed here
    '{1'b0, 1'b1, 4'b1111, 4'd1, Z0, 1'b0, 4'd5,  1'b1, M1}, // R5 partial bypass
    '{1'b0, 1'b1, 4'b1111, 4'd1, Z0, 1'b1, 4'd7,  1'b1, M1}, // R7 repeat stable
    '{1'b0, 1'b0, 4'b0000, 4'd3, Z0, 1'b0, 4'd9,  1'b0, M1}, // R9 oe_n high hides read
    '{1'b0, 1'b0, 4'b0101, 4'd2, D3, 1'b0, 4'd11, 1'b0, M1}, // R11 back-to-back writes
    '{1'b0, 1'b1, 4'b1111, 4'd3, D4, 1'b0, 4'd11, 1'b0, M1},
    '{1'b0, 1'b1, 4'b1111, 4'd2, Z0, 1'b0, 4'd11, 1'b1, D3}, // R11 a3 committed
    '{1'b0, 1'b1, 4'b1111, 4'd1, Z0, 1'b0, 4'd6,  1'b1, M2}, // R6 bytes 3,1 bypassed
    '{1'b1, 1'b1, 4'b1111, 4'd0, Z0, 1'b0, 4'd4,  1'b1, M1}, // R4 a1 byte0 committed
    '{1'b0, 1'b0, 4'b1111, 4'd2, Z0, 1'b0, 4'd8,  1'b0, M1}, // R8 deselect holds data
    '{1'b1, 1'b1, 4'b1111, 4'd0, D5, 1'b0, 4'd6,  1'b0, M1},
    '{1'b0, 1'b1, 4'b1111, 4'd2, Z0, 1'b0, 4'd6,  1'b0, M1},
    '{1'b1, 1'b1, 4'b1111, 4'd0, Z0, 1'b0, 4'd6,  1'b1, M2}  // R6 empty write kept a2
  };

  task automatic check(input string tag, input logic en_x, input logic [35:0] dat_x);
    n_chk++;
    if (rdata_en !== en_x || rdata !== dat_x) begin
      n_bad++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
               tag, rdata_en, rdata, en_x, dat_x);
    end
  endtask

  task automatic step(input logic s_n, input logic w_n, input logic [3:0] b_n,
                      input logic [3:0] a, input logic [35:0] wd,
                      input logic o_n, input logic slp);
    @(negedge clk);
    sel_n = s_n; we_n = w_n; be_n = b_n; addr = a; wdata = wd;
    oe_n = o_n; sleep = slp;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 1'b0, Z0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset", 1'b0, Z0);

    for (int i = 0; i < NROW; i++) begin
      step(TBL[i].sel_n, TBL[i].we_n, TBL[i].be_n, TBL[i].addr,
           TBL[i].wd, TBL[i].oe_n, 1'b0);
      check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].en_x, TBL[i].dat_x);
    end

    // R10: sleep ignores commands and data, keeps the buffer
    step(1'b0, 1'b0, 4'b0000, 4'd4, Z0, 1'b0, 1'b0); // write a4
    step(1'b1, 1'b1, 4'b1111, 4'd0, D6, 1'b0, 1'b0); // D6 captured
    step(1'b0, 1'b0, 4'b0000, 4'd4, Z0, 1'b0, 1'b1); // ignored write
    check("R10 sleep output off", 1'b0, M2);
    step(1'b0, 1'b1, 4'b1111, 4'd4, D7, 1'b0, 1'b1); // ignored read and data
    check("R10 sleep output off again", 1'b0, M2);
    step(1'b0, 1'b1, 4'b1111, 4'd4, Z0, 1'b0, 1'b0); // read a4 awake
    check("R10 wake no stray read", 1'b0, M2);
    step(1'b1, 1'b1, 4'b1111, 4'd0, Z0, 1'b0, 1'b0);
    check("R10 content kept", 1'b1, D6);
    step(1'b0, 1'b1, 4'b1111, 4'd1, Z0, 1'b0, 1'b0); // read a1
    step(1'b1, 1'b1, 4'b1111, 4'd0, Z0, 1'b0, 1'b1); // sleep at output edge
    check("R10 pending read hidden", 1'b0, D6);
    step(1'b0, 1'b1, 4'b1111, 4'd1, Z0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 4'b1111, 4'd0, Z0, 1'b0, 1'b0);
    check("R2 read after wake", 1'b1, M1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: en=%0b data=%h expected completion", rdata_en, rdata);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule